// File: doc/BRIEF.md
# Power Button Event Controller

This block watches an active-low power button and turns its presses into single-cycle power management events. The raw pin is synchronised to the clock and then filtered. A change of level counts as real only once it has been stable for a set number of ticks from a 1 kHz enable input. When a press is accepted, the block looks at the current sleep state code. From the working state it raises a sleep request pulse, which the surrounding logic routes as an SMI or SCI. From any sleep state it raises a wake pulse instead.

A separate hold timer starts when the press is accepted. If the button is still held after the long threshold, the block issues one force-soft-off pulse, whatever the state code is. A further override needs a release and a fresh press. Releasing the button never produces an event, so a press that ended in an override does not also request sleep or wake.

State code encoding on `slp_state`: 0 means working, 1 to 4 mean the sleep states S1 to S4, and 5 means soft-off (S5).

Top module: `pwrbtn_evt`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `sleep_req`, `wake_evt` and `force_off` are all 0.
- R2: The button is pressed when `btn_n` is 0. A press or release is accepted only after the synchronised pin has held the new level for DEB_TICKS consecutive ticks. A glitch shorter than that produces no event, and a short release glitch during a held press does not start a second press.
- R3: A press accepted while `slp_state` is 0 gives exactly one `sleep_req` pulse and no `wake_evt` pulse.
- R4: A press accepted while `slp_state` is 1 to 5 gives exactly one `wake_evt` pulse and no `sleep_req` pulse. The two never assert together.
- R5: If the button stays pressed for HOLD_TICKS ticks after the press is accepted, `force_off` pulses once, for every state code 0 to 5.
- R6: One press yields at most one `force_off` pulse, however long it is held. A new override needs a release and a new press.
- R7: Releasing the button, including after an override, produces no `sleep_req`, `wake_evt` or `force_off` pulse.
- R8: Debounce and hold counting advance only on cycles where `tick_ms` is 1. Without ticks, a held button produces no event.
- R9: Each of `sleep_req`, `wake_evt` and `force_off` is high for exactly one clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_n | input | 1 | Raw power button pin, 0 = pressed |
| slp_state | input | STW | Current state code: 0 working, 1-4 S1-S4, 5 S5 |
| tick_ms | input | 1 | One-cycle enable at the 1 kHz tick rate |
| sleep_req | output | 1 | Sleep request pulse for a press in the working state |
| wake_evt | output | 1 | Wake pulse for a press in a sleep state |
| force_off | output | 1 | Unconditional soft-off pulse after a long hold |

## Verification
The bench runs with a scaled-down tick and small thresholds. It drives these patterns:
- Press glitches shorter than the debounce window, which separate a real filter from a plain edge detector.
- Release glitches inside a held press, which show that the filter works in both directions.
- Short presses in the working state and in a sleep state, which tell the sleep request from the wake event.
- Long holds in each of the six state codes, which show that the override ignores the state.
- Holds of well over twice the threshold followed by a second long press, which show one override per press.
- Presses with the tick stopped, which show that only the enable advances the timers.

A behavioural reference model is compared on every clock.

// File: rtl/pwrbtn_evt.sv
module pwrbtn_evt #(
  parameter int DEB_TICKS  = 16,
  parameter int HOLD_TICKS = 4000,
  parameter int STW        = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           btn_n,
  input  logic [STW-1:0] slp_state,
  input  logic           tick_ms,
  output logic           sleep_req,
  output logic           wake_evt,
  output logic           force_off
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [1:0]    sync;
  logic          deb, fired;
  logic [DW-1:0] dcnt;
  logic [HW-1:0] hcnt;

  wire raw    = ~sync[1];
  wire accept = tick_ms && (raw != deb) && (dcnt == DW'(DEB_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 2'b11;
      deb       <= 1'b0;
      dcnt      <= '0;
      hcnt      <= '0;
      fired     <= 1'b0;
      sleep_req <= 1'b0;
      wake_evt  <= 1'b0;
      force_off <= 1'b0;
    end else begin
      sync      <= {sync[0], btn_n};
      sleep_req <= 1'b0;
      wake_evt  <= 1'b0;
      force_off <= 1'b0;

      if (raw == deb) begin
        dcnt <= '0;
      end else if (tick_ms) begin
        if (accept) begin
          deb  <= raw;
          dcnt <= '0;
          if (raw) begin
            sleep_req <= (slp_state == '0);
            wake_evt  <= (slp_state != '0);
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end

      if (!deb) begin
        hcnt  <= '0;
        fired <= 1'b0;
      end else if (tick_ms && !fired) begin
        if (hcnt == HW'(HOLD_TICKS - 1)) begin
          force_off <= 1'b1;
          fired     <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

module pwrbtn_evt_chk #(
  parameter int STW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           btn_n,
  input logic [STW-1:0] slp_state,
  input logic           tick_ms,
  input logic           sleep_req,
  input logic           wake_evt,
  input logic           force_off
);
  assert_pulse_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !sleep_req);
  assert_pulse_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !wake_evt);
  assert_pulse_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !force_off);
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_req && wake_evt));
  assert_sleep_working_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> $past(slp_state) == '0);
  assert_wake_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> $past(slp_state) != '0);
  assert_press_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req || wake_evt) |-> $past(btn_n, 3) == 1'b0);
  assert_tick_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req || wake_evt || force_off) |-> $past(tick_ms));
endmodule

bind pwrbtn_evt pwrbtn_evt_chk #(.STW(STW)) chk (.*);

// File: tb/pwrbtn_evt_test.sv
module pwrbtn_evt_test;
  localparam int DEB = 4;
  localparam int HOLD = 20;
  localparam int TP = 5;

  logic clk = 1'b0, rst_n = 1'b0, btn_n = 1'b1, tick_ms = 1'b0, tick_en = 1'b1;
  logic [2:0] slp_state = '0;
  logic sleep_req, wake_evt, force_off;
  int errors = 0, checks = 0, phase = 0;
  int n_sleep = 0, n_wake = 0, n_off = 0;
  bit done = 0;

  pwrbtn_evt #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .STW(3)) uut (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .slp_state(slp_state),
    .tick_ms(tick_ms), .sleep_req(sleep_req), .wake_evt(wake_evt), .force_off(force_off));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    phase   = (phase == TP - 1) ? 0 : phase + 1;
    tick_ms = tick_en && (phase == TP - 1);
  end

  // behavioural reference
  bit m_s1 = 1, m_s2 = 1, m_deb = 0, m_fired = 0;
  int m_cnt = 0, m_hold = 0;
  bit e_sleep = 0, e_wake = 0, e_off = 0;
  always @(posedge clk) begin
    bit raw, old_deb;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_deb = 0; m_fired = 0; m_cnt = 0; m_hold = 0;
      e_sleep = 0; e_wake = 0; e_off = 0;
    end else begin
      raw = !m_s2; old_deb = m_deb;
      m_s2 = m_s1; m_s1 = btn_n;
      e_sleep = 0; e_wake = 0; e_off = 0;
      if (raw == m_deb) m_cnt = 0;
      else if (tick_ms) begin
        m_cnt++;
        if (m_cnt == DEB) begin
          m_deb = raw; m_cnt = 0;
          if (raw) begin e_sleep = (slp_state == 0); e_wake = (slp_state != 0); end
        end
      end
      if (!old_deb) begin m_hold = 0; m_fired = 0; end
      else if (tick_ms && !m_fired) begin
        m_hold++;
        if (m_hold == HOLD) begin e_off = 1; m_fired = 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (sleep_req) n_sleep++;
    if (wake_evt) n_wake++;
    if (force_off) n_off++;
    if (!done) begin
      chk(sleep_req == e_sleep, "R3 sleep_req vs model", sleep_req, e_sleep);
      chk(wake_evt == e_wake, "R4 wake_evt vs model", wake_evt, e_wake);
      chk(force_off == e_off, "R5 force_off vs model", force_off, e_off);
    end
  end

  task automatic clr();
    @(negedge clk); n_sleep = 0; n_wake = 0; n_off = 0;
  endtask

  task automatic hold_lvl(input bit lvl, input int n);
    @(negedge clk); btn_n = lvl;
    repeat (n) begin
      @(posedge clk);
      while (!tick_ms) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic counts(input string tag, input int s, input int w, input int o);
    chk(n_sleep == s, {tag, " sleep count"}, n_sleep, s);
    chk(n_wake == w, {tag, " wake count"}, n_wake, w);
    chk(n_off == o, {tag, " off count"}, n_off, o);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sleep_req && !wake_evt && !force_off, "R1 outputs in reset",
        {sleep_req, wake_evt, force_off}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sleep_req && !wake_evt && !force_off, "R1 outputs after reset",
        {sleep_req, wake_evt, force_off}, 0);
    hold_lvl(1, 6);

    clr(); hold_lvl(0, 2); hold_lvl(1, 8);
    counts("R2 short glitch", 0, 0, 0);

    clr(); hold_lvl(0, 8); hold_lvl(1, 2); hold_lvl(0, 4); hold_lvl(1, 8);
    counts("R2 R3 short press working with release glitch", 1, 0, 0);

    slp_state = 3'd3;
    clr(); hold_lvl(0, 8); hold_lvl(1, 8);
    counts("R4 short press in S3", 0, 1, 0);

    for (int s = 0; s <= 5; s++) begin
      slp_state = 3'(s);
      clr(); hold_lvl(0, HOLD + DEB + 6);
      counts($sformatf("R5 long hold state %0d", s), (s == 0) ? 1 : 0, (s == 0) ? 0 : 1, 1);
      clr(); hold_lvl(1, 10);
      counts($sformatf("R7 release after override state %0d", s), 0, 0, 0);
    end

    slp_state = 3'd2;
    clr(); hold_lvl(0, 3 * HOLD);
    counts("R6 very long hold", 0, 1, 1);
    hold_lvl(1, 10);
    clr(); hold_lvl(0, HOLD + DEB + 6); hold_lvl(1, 10);
    counts("R6 second press overrides again", 0, 1, 1);

    slp_state = 3'd0;
    @(negedge clk); tick_en = 1'b0;
    clr(); @(negedge clk); btn_n = 1'b0;
    repeat (300) @(negedge clk);
    counts("R8 no ticks", 0, 0, 0);
    tick_en = 1'b1;
    hold_lvl(0, 8);
    counts("R8 ticks resumed", 1, 0, 0);
    hold_lvl(1, 10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule